// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block sits between the interrupt pins of a small microcontroller-style core and the core itself. It takes a few dedicated external interrupt pins plus one port of pin-change inputs. Every pin first goes through a two-flop synchronizer. Each dedicated pin is then sensed according to its own mode, which is rising edge, falling edge, low level or off. All pin-change inputs share one source. The block keeps one pending bit per source and a global interrupt enable. From these it issues a single prioritized request and a vector index to the core.

The global enable is held by a three-state machine:
- `ST_MASKED`: the enable is clear and the core has not yet set it. This is the state after reset.
- `ST_ARMED`: the enable is set and requests may go out.
- `ST_SERVICE`: the core has accepted an interrupt and the enable is clear again.

The machine has three transitions:
- SET: `gie_set` moves the machine from `ST_MASKED` to `ST_ARMED`.
- ACCEPT: `irq_ack` while a request is out moves it from `ST_ARMED` to `ST_SERVICE` and records the winning source.
- RETURN: `irq_ret` moves it from `ST_SERVICE` back to `ST_ARMED` and clears the pending bit of the recorded source.

Edge-sensed sources latch a sticky one-bit flag. This flag also captures events that arrive while interrupts are masked. Low-level sources do not latch, and their pending bit follows the qualified level.

Top module: `irq_front_unit`

## Requirements
- R1: Each dedicated pin i has a two-bit mode in `ext_mode[2i+1:2i]`: 00 rising edge, 01 falling edge, 10 low level, 11 off. An edge of the wrong direction, and any activity in the off mode, leaves its pending bit at 0.
- R2: In the edge modes, a matching edge sets pending bit i whatever the machine state is. The bit stays set until it is cleared.
- R3: In low-level mode, pending bit i is 1 only after the synchronized pin has been low for LEVEL_HOLD consecutive cycles. It returns to 0 once the pin is high again, and nothing is latched.
- R4: ACCEPT (`irq_ack` high while `irq_req` is high) moves the machine to `ST_SERVICE`. From the next cycle `gie` and `irq_req` are 0.
- R5: RETURN (`irq_ret` in `ST_SERVICE`) moves the machine to `ST_ARMED` with `gie` at 1. It also clears the pending bit of the source that was accepted.
- R6: Several events of one source before service collapse into one pending bit, so after RETURN no further request remains from them.
- R7: A change in either direction on any pin-change input whose `pc_pin_en` bit is 1 sets the shared pending bit at index NUM_EXT. Changes on pins whose enable bit is 0 are ignored.
- R8: `irq_req` is 1 when the machine is in `ST_ARMED` and any bit of `pend_flags & src_en` is set. `irq_vec` is the lowest such index, with the dedicated pins at indices 0..NUM_EXT-1 ranked above the pin-change source. `irq_vec` is 0 when no source is active.
- R9: A 1 in `flag_clr[i]` clears latched pending bit i. If an edge and a clear arrive in the same cycle, the bit stays set.
- R10: After reset the machine is in `ST_MASKED` with `gie`, `irq_req` and `pend_flags` all 0. Outside `ST_ARMED`, `irq_req` is 0 while pending bits keep collecting, and SET moves the machine to `ST_ARMED`.
- R11: A pin edge shows in `pend_flags` at the third rising clock edge after the pin changes: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | NUM_EXT | Dedicated interrupt pins (asynchronous, idle high) |
| ext_mode | input | 2*NUM_EXT | Sense mode per dedicated pin |
| pc_pin | input | NUM_PC | Pin-change port inputs (asynchronous) |
| pc_pin_en | input | NUM_PC | Per-pin enable for change detection |
| src_en | input | NUM_EXT+1 | Per-source request enable |
| flag_clr | input | NUM_EXT+1 | Write-1-to-clear pulses for pending bits |
| gie_set | input | 1 | SET: enable interrupts from `ST_MASKED` |
| irq_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Core returns from service |
| irq_req | output | 1 | Prioritized interrupt request |
| irq_vec | output | clog2(NUM_EXT+1) | Index of the winning source |
| gie | output | 1 | Global interrupt enable |
| pend_flags | output | NUM_EXT+1 | Pending bit per source |

## Verification
The bench raises an edge while the machine is masked and confirms that it is still served later. A design that only senses edges while enabled would lose that event. It gives one source two events before service and checks that RETURN leaves nothing pending, which catches a counter in place of a flag or a missing clear on RETURN. It times the edge-against-clear collision to the exact cycle, where a design that gives the clear priority drops the event. It holds a low level one cycle short of and then exactly at the qualification time, which exposes an off-by-one in the hold counter or a latched level source. A table of event and enable combinations checks the priority order and the pin-change merge, including a disabled pin-change input that must not raise the shared flag.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
    typedef enum logic [1:0] {
        SENSE_RISE = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_OFF  = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        ST_MASKED  = 2'b00,
        ST_ARMED   = 2'b01,
        ST_SERVICE = 2'b10
    } gie_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W       = 1,
    parameter bit RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= {W{RST_BIT}};
            stage2_q <= {W{RST_BIT}};
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
    import irq_front_pkg::*;
#(
    parameter int HOLD = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_e mode,
    input  logic   clr,
    output logic   pend
);
    localparam int CW = $clog2(HOLD + 1);

    logic          prev_q;
    logic          flag_q;
    logic [CW-1:0] low_cnt_q;
    logic          edge_mode;
    logic          hit;

    assign edge_mode = (mode == SENSE_RISE) || (mode == SENSE_FALL);
    assign hit = ((mode == SENSE_RISE) && pin_s && !prev_q) ||
                 ((mode == SENSE_FALL) && !pin_s && prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b1;
            flag_q    <= 1'b0;
            low_cnt_q <= '0;
        end else begin
            prev_q <= pin_s;
            if (!edge_mode)      flag_q <= 1'b0;
            else if (hit)        flag_q <= 1'b1;
            else if (clr)        flag_q <= 1'b0;
            if ((mode == SENSE_LOW) && !pin_s) begin
                if (low_cnt_q != CW'(HOLD)) low_cnt_q <= low_cnt_q + CW'(1);
            end else begin
                low_cnt_q <= '0;
            end
        end
    end

    assign pend = edge_mode ? flag_q
                            : ((mode == SENSE_LOW) && (low_cnt_q == CW'(HOLD)));
endmodule

// File: rtl/irq_pc_detect.sv
module irq_pc_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic [N-1:0] pin_en,
    input  logic         clr,
    output logic         pend
);
    logic [N-1:0] prev_q;
    logic         flag_q;
    logic         changed;

    assign changed = |((pin_s ^ prev_q) & pin_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (changed)  flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign pend = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 3,
    parameter int VW   = 2
) (
    input  logic [NSRC-1:0] active,
    output logic            any,
    output logic [VW-1:0]   win
);
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active[i]) win = VW'(i);
        end
    end

    assign any = |active;
endmodule

// File: rtl/irq_front_unit.sv
module irq_front_unit
    import irq_front_pkg::*;
#(
    parameter int NUM_EXT    = 2,
    parameter int NUM_PC     = 4,
    parameter int LEVEL_HOLD = 5,
    localparam int NSRC      = NUM_EXT + 1,
    localparam int VW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin,
    input  logic [2*NUM_EXT-1:0] ext_mode,
    input  logic [NUM_PC-1:0]    pc_pin,
    input  logic [NUM_PC-1:0]    pc_pin_en,
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC-1:0]      flag_clr,
    input  logic                 gie_set,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_req,
    output logic [VW-1:0]        irq_vec,
    output logic                 gie,
    output logic [NSRC-1:0]      pend_flags
);
    gie_state_e state_q, state_d;
    logic [VW-1:0]      svc_q;
    logic [NSRC-1:0]    ret_clr;
    logic [NSRC-1:0]    src_clr;
    logic [NUM_EXT-1:0] ext_s;
    logic [NUM_PC-1:0]  pc_s;
    logic               arb_any;
    logic [VW-1:0]      arb_win;
    logic               accept;
    logic               ret_done;

    irq_sync #(.W(NUM_EXT), .RST_BIT(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .dout(ext_s));
    irq_sync #(.W(NUM_PC), .RST_BIT(1'b0)) u_pc_sync (
        .clk(clk), .rst_n(rst_n), .din(pc_pin), .dout(pc_s));

    assign ret_done = (state_q == ST_SERVICE) && irq_ret;
    assign ret_clr  = ret_done ? (NSRC'(1) << svc_q) : '0;
    assign src_clr  = flag_clr | ret_clr;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        irq_ext_sense #(.HOLD(LEVEL_HOLD)) u_sense (
            .clk(clk), .rst_n(rst_n), .pin_s(ext_s[g]),
            .mode(sense_e'(ext_mode[2*g +: 2])),
            .clr(src_clr[g]), .pend(pend_flags[g]));
    end

    irq_pc_detect #(.N(NUM_PC)) u_pc (
        .clk(clk), .rst_n(rst_n), .pin_s(pc_s), .pin_en(pc_pin_en),
        .clr(src_clr[NUM_EXT]), .pend(pend_flags[NUM_EXT]));

    irq_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
        .active(pend_flags & src_en), .any(arb_any), .win(arb_win));

    assign accept = (state_q == ST_ARMED) && arb_any && irq_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MASKED;
        else        state_q <= state_d;
    end

    // Served-source record, captured on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      svc_q <= '0;
        else if (accept) svc_q <= arb_win;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED:  if (gie_set)  state_d = ST_ARMED;    // SET
            ST_ARMED:   if (accept)   state_d = ST_SERVICE;  // ACCEPT
            ST_SERVICE: if (irq_ret)  state_d = ST_ARMED;    // RETURN
            default:                  state_d = ST_MASKED;
        endcase
    end

    // Outputs
    always_comb begin
        gie     = 1'b0;
        irq_req = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                gie     = 1'b1;
                irq_req = arb_any;
            end
            ST_MASKED, ST_SERVICE: ;
            default: ;
        endcase
        irq_vec = arb_win;
    end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
    import irq_front_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int VW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic [VW-1:0]   irq_vec,
    input logic            gie,
    input logic [NSRC-1:0] pend_flags,
    input logic [NSRC-1:0] src_en,
    input logic            irq_ack,
    input logic            irq_ret,
    input gie_state_e      state
);
    logic [NSRC-1:0] act;
    logic [NSRC-1:0] below;

    assign act   = pend_flags & src_en;
    assign below = (NSRC'(1) << irq_vec) - NSRC'(1);

    AST_REQ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);  // R10
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (!gie && !irq_req));  // R4
    AST_RET_RESTORES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && state == ST_SERVICE) |=> gie);  // R5
    AST_VEC_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> act[irq_vec]);  // R8
    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((act & below) == '0));  // R8
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (!irq_req && irq_vec == '0));  // R8
endmodule

bind irq_front_unit irq_front_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .gie(gie), .pend_flags(pend_flags), .src_en(src_en),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .state(state_q));

// File: tb/irq_front_unit_tb.sv
`timescale 1ns/1ps
module irq_front_unit_tb;
    localparam int NUM_EXT = 2;
    localparam int NUM_PC  = 4;
    localparam int HOLD    = 5;
    localparam int NSRC    = NUM_EXT + 1;
    localparam int VW      = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic [NUM_EXT-1:0]   ext_pin;
    logic [2*NUM_EXT-1:0] ext_mode;
    logic [NUM_PC-1:0]    pc_pin, pc_pin_en;
    logic [NSRC-1:0]      src_en, flag_clr;
    logic gie_set, irq_ack, irq_ret;
    logic irq_req, gie;
    logic [VW-1:0]   irq_vec;
    logic [NSRC-1:0] pend_flags;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_front_unit #(.NUM_EXT(NUM_EXT), .NUM_PC(NUM_PC), .LEVEL_HOLD(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_mode(ext_mode),
        .pc_pin(pc_pin), .pc_pin_en(pc_pin_en), .src_en(src_en),
        .flag_clr(flag_clr), .gie_set(gie_set), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .gie(gie), .pend_flags(pend_flags));

    // entry: {events[2:0], src_en[2:0], exp_req, exp_vec[1:0]}
    // events bit0/1 = falling edge on ext pin 0/1, bit2 = toggle pc_pin[0]
    localparam logic [8:0] TBL [6] = '{
        {3'b111, 3'b111, 1'b1, 2'd0},
        {3'b110, 3'b111, 1'b1, 2'd1},
        {3'b100, 3'b111, 1'b1, 2'd2},
        {3'b011, 3'b110, 1'b1, 2'd1},
        {3'b101, 3'b011, 1'b1, 2'd0},
        {3'b100, 3'b011, 1'b0, 2'd0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_clr = '1; step(1); flag_clr = '0; step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_pin = '1; ext_mode = 4'b0101; pc_pin = '0;
        pc_pin_en = 4'b0011; src_en = '1; flag_clr = '0;
        gie_set = 0; irq_ack = 0; irq_ret = 0;
        step(3); rst_n = 1'b1; step(1);

        // R10 reset state
        chk("R10 reset gie", gie, 0);
        chk("R10 reset req", irq_req, 0);
        chk("R10 reset pend", pend_flags, 0);

        // R2 / R11 masked edge is held
        ext_pin[0] = 1'b0; step(2);
        chk("R11 not yet after two edges", pend_flags[0], 0);
        step(1);
        chk("R2 masked edge latched", pend_flags[0], 1);
        chk("R10 req low while masked", irq_req, 0);
        gie_set = 1; step(1); gie_set = 0;
        chk("R10 SET enables gie", gie, 1);
        chk("R8 req after SET", irq_req, 1);
        chk("R8 vec after SET", irq_vec, 0);

        // R6 second event before service
        ext_pin[0] = 1'b1; step(3); ext_pin[0] = 1'b0; step(3);
        chk("R6 flag single bit", pend_flags, 3'b001);
        irq_ack = 1; step(1); irq_ack = 0;
        chk("R4 ACCEPT clears gie", gie, 0);
        chk("R4 req low in service", irq_req, 0);
        chk("R10 flag kept in service", pend_flags[0], 1);
        irq_ret = 1; step(1); irq_ret = 0;
        chk("R5 RETURN sets gie", gie, 1);
        chk("R5 RETURN clears flag", pend_flags[0], 0);
        chk("R6 no second request", irq_req, 0);
        ext_pin[0] = 1'b1; step(3);

        // R8 / R7 table of event and enable combinations
        for (int k = 0; k < 6; k++) begin
            logic [2:0] ev;
            ev = TBL[k][8:6];
            src_en = TBL[k][5:3];
            ext_pin = ~ev[1:0];
            if (ev[2]) pc_pin[0] = ~pc_pin[0];
            step(3);
            chk($sformatf("R8 table %0d req", k), irq_req, TBL[k][2]);
            chk($sformatf("R8 table %0d vec", k), irq_vec, TBL[k][1:0]);
            chk($sformatf("R7 table %0d pc flag", k), pend_flags[2], ev[2]);
            ext_pin = '1; step(3);
            clear_all();
            src_en = '1;
            chk($sformatf("R9 table %0d cleared", k), pend_flags, 0);
        end

        // R9 edge beats clear in the same cycle
        ext_pin[0] = 1'b0; step(2);
        flag_clr = 3'b001; step(1); flag_clr = '0;
        chk("R9 edge wins over clear", pend_flags[0], 1);
        flag_clr = 3'b001; step(1); flag_clr = '0;
        chk("R9 write-1 clears", pend_flags[0], 0);
        chk("R9 no req after clear", irq_req, 0);
        ext_pin[0] = 1'b1; step(3);

        // R7 disabled pin-change input ignored, both directions on enabled pin
        pc_pin[3] = ~pc_pin[3]; step(3);
        chk("R7 disabled pin ignored", pend_flags[2], 0);
        pc_pin[1] = 1'b1; step(3);
        chk("R7 rising change", pend_flags[2], 1);
        clear_all();
        pc_pin[1] = 1'b0; step(3);
        chk("R7 falling change", pend_flags[2], 1);
        chk("R8 pc vector", irq_vec, 2);
        clear_all();

        // R1 rising mode and off mode
        ext_mode[1:0] = 2'b00;
        ext_pin[0] = 1'b0; step(3);
        chk("R1 rising mode ignores fall", pend_flags[0], 0);
        ext_pin[0] = 1'b1; step(3);
        chk("R1 rising mode catches rise", pend_flags[0], 1);
        clear_all();
        ext_mode[1:0] = 2'b11;
        ext_pin[0] = 1'b0; step(3); ext_pin[0] = 1'b1; step(3);
        chk("R1 off mode ignores pin", pend_flags[0], 0);

        // R3 low level qualification, no latching
        ext_mode[3:2] = 2'b10;
        ext_pin[1] = 1'b0; step(2 + HOLD - 1);
        chk("R3 one cycle short", pend_flags[1], 0);
        chk("R3 no req yet", irq_req, 0);
        step(1);
        chk("R3 qualified level", pend_flags[1], 1);
        chk("R3 req vec", irq_vec, 1);
        irq_ack = 1; step(1); irq_ack = 0;
        chk("R4 level accept", gie, 0);
        irq_ret = 1; step(1); irq_ret = 0;
        chk("R3 level still live after return", pend_flags[1], 1);
        ext_pin[1] = 1'b1; step(3);
        chk("R3 release drops pending", pend_flags[1], 0);
        chk("R3 release drops req", irq_req, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule